// File: doc/BRIEF.md
# Field-Half Operand Fetch Stage

This block is the operand fetch stage of a pipelined packed-field (SWAR) datapath. It holds a register file of 2^A registers, each 2^K bits wide, and reads two source registers at once for the execute stage. Each source operand has its own read address and its own pair of modifier controls. When a modifier is active, every field of the chosen width inside the operand is replaced by one of its halves, right-aligned inside the field with zeros above it. The ALU then receives operands already reshaped to the half-width layout. A single write port stores results coming back from execute.

Field width comes in as a one-hot vector: bit k selects fields of 2^k bits, and the top bit selects the whole register as one field. The low-half modifier keeps the lower half of each field. The high-half modifier moves the upper half of each field down into the lower half. Either operand may use a modifier, or both may, each on its own. Requesting both halves on one operand is illegal. The block then passes that operand through unchanged and raises that operand's error flag.

Top module: `halfmod_fetch`

## Requirements
- R1: After reset every register reads as zero on both operand outputs.
- R2: When `wrEn` is high, `wrData` is stored into register `wrAddr` at the rising clock edge. A read of that register in the same cycle returns the value it held before the write, and a read in the following cycle returns the new value.
- R3: With both modifier controls low, an operand output equals the addressed register.
- R4: With only the low control (`lA`/`lB`) high and field width 2^k (k ≥ 1), each field of 2^k bits keeps its lower 2^(k-1) bits in place, and its upper 2^(k-1) bits become zero.
- R5: With only the high control (`hA`/`hB`) high and field width 2^k (k ≥ 1), the upper 2^(k-1) bits of each field move into the lower half of that field, and the upper half becomes zero.
- R6: Operand A and operand B use their own addresses and modifier controls, with no effect on each other.
- R7: When both modifier controls of an operand are high, that operand passes through unchanged and its error output is high. The error output is low in every other case.
- R8: A modifier with field width 1 bit (`fieldWidth` bit 0) leaves the operand unchanged and raises no error.
- R9: When `fieldWidth` does not have exactly one bit set, both operands pass through unchanged. Errors are still raised only as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | ADDR_W | Register address of operand A |
| hA | input | 1 | Operand A high-half modifier |
| lA | input | 1 | Operand A low-half modifier |
| rdAddrB | input | ADDR_W | Register address of operand B |
| hB | input | 1 | Operand B high-half modifier |
| lB | input | 1 | Operand B low-half modifier |
| fieldWidth | input | LOG_N+1 | One-hot field width; bit k selects 2^k-bit fields |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Write destination register |
| wrData | input | 2^LOG_N | Write data |
| opA | output | 2^LOG_N | Operand A, possibly modified |
| opB | output | 2^LOG_N | Operand B, possibly modified |
| errA | output | 1 | Operand A illegal modifier pair |
| errB | output | 1 | Operand B illegal modifier pair |

## Verification
The bench builds the block with ADDR_W = 2 and LOG_N = 4: four registers of 16 bits and five field widths, from 1 bit up to the whole register. At this size it can try every pair of read addresses against every width and all sixteen modifier combinations of the two operands. That covers the whole-register width, the undefined 1-bit width and the illegal both-halves request. The register contents come from a distinct arithmetic pattern, so a field half taken from the wrong place or a missing zero fill shows up in the result.

// File: rtl/halfmod_pkg.sv
package halfmod_pkg;

  // Strobes from control to datapath for one source operand
  typedef struct packed {
    logic useHigh;
    logic useLow;
    logic modErr;
  } modStrobe_t;

endpackage

// File: rtl/halfmod_ctrl.sv
module halfmod_ctrl
  import halfmod_pkg::*;
#(
  parameter int LOG_N = 5
) (
  input  logic             hA,
  input  logic             lA,
  input  logic             hB,
  input  logic             lB,
  input  logic [LOG_N:0]   fieldWidth,
  output modStrobe_t       strobeA,
  output modStrobe_t       strobeB,
  output logic [LOG_N:0]   widthOh
);

  logic widthOk;

  // A width is usable only when exactly one bit is set and it is not the 1-bit width
  always_comb begin
    widthOk = $onehot(fieldWidth) && !fieldWidth[0];
    widthOh = widthOk ? fieldWidth : '0;
  end

  always_comb begin
    strobeA.useHigh = widthOk && hA && !lA;
    strobeA.useLow  = widthOk && lA && !hA;
    strobeA.modErr  = hA && lA;
    strobeB.useHigh = widthOk && hB && !lB;
    strobeB.useLow  = widthOk && lB && !hB;
    strobeB.modErr  = hB && lB;
  end

endmodule

// File: rtl/halfmod_shaper.sv
module halfmod_shaper
  import halfmod_pkg::*;
#(
  parameter int LOG_N = 5,
  localparam int N = 1 << LOG_N
) (
  input  logic [N-1:0]   rawOp,
  input  modStrobe_t     strobe,
  input  logic [LOG_N:0] widthOh,
  output logic [N-1:0]   shapedOp
);

  logic [N-1:0] cand [LOG_N:1];

  // One candidate result per field width; each field takes the chosen half
  for (genvar k = 1; k <= LOG_N; k++) begin : g_width
    localparam int FW   = 1 << k;
    localparam int HW   = FW / 2;
    localparam int NFLD = N / FW;
    for (genvar f = 0; f < NFLD; f++) begin : g_field
      assign cand[k][f*FW +: FW] = strobe.useHigh
        ? {{HW{1'b0}}, rawOp[f*FW + HW +: HW]}
        : {{HW{1'b0}}, rawOp[f*FW +: HW]};
    end
  end

  logic [N-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 1; k <= LOG_N; k++) begin
      if (widthOh[k]) picked = picked | cand[k];
    end
    shapedOp = (strobe.useHigh || strobe.useLow) ? picked : rawOp;
  end

endmodule

// File: rtl/halfmod_datapath.sv
module halfmod_datapath
  import halfmod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LOG_N  = 5,
  localparam int N     = 1 << LOG_N,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [N-1:0]      wrData,
  input  modStrobe_t        strobeA,
  input  modStrobe_t        strobeB,
  input  logic [LOG_N:0]    widthOh,
  output logic [N-1:0]      opA,
  output logic [N-1:0]      opB
);

  logic [N-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  logic [N-1:0] rawA, rawB;

  assign rawA = regs[rdAddrA];
  assign rawB = regs[rdAddrB];

  halfmod_shaper #(.LOG_N(LOG_N)) shapeA_i (
    .rawOp(rawA), .strobe(strobeA), .widthOh(widthOh), .shapedOp(opA)
  );

  halfmod_shaper #(.LOG_N(LOG_N)) shapeB_i (
    .rawOp(rawB), .strobe(strobeB), .widthOh(widthOh), .shapedOp(opB)
  );

endmodule

// File: rtl/halfmod_fetch.sv
module halfmod_fetch
  import halfmod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LOG_N  = 5,
  localparam int N     = 1 << LOG_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              hA,
  input  logic              lA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              hB,
  input  logic              lB,
  input  logic [LOG_N:0]    fieldWidth,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [N-1:0]      wrData,
  output logic [N-1:0]      opA,
  output logic [N-1:0]      opB,
  output logic              errA,
  output logic              errB
);

  modStrobe_t     strobeA, strobeB;
  logic [LOG_N:0] widthOh;

  halfmod_ctrl #(.LOG_N(LOG_N)) ctrl_i (
    .hA(hA), .lA(lA), .hB(hB), .lB(lB),
    .fieldWidth(fieldWidth),
    .strobeA(strobeA), .strobeB(strobeB), .widthOh(widthOh)
  );

  halfmod_datapath #(.ADDR_W(ADDR_W), .LOG_N(LOG_N)) dp_i (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobeA(strobeA), .strobeB(strobeB), .widthOh(widthOh),
    .opA(opA), .opB(opB)
  );

  assign errA = strobeA.modErr;
  assign errB = strobeB.modErr;

endmodule

// File: rtl/halfmod_fetch_chk.sv
module halfmod_fetch_chk #(
  parameter int ADDR_W = 3,
  parameter int LOG_N  = 5,
  localparam int N     = 1 << LOG_N
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic              hA,
  input logic              lA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic              hB,
  input logic              lB,
  input logic [LOG_N:0]    fieldWidth,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [N-1:0]      wrData,
  input logic [N-1:0]      opA,
  input logic [N-1:0]      opB,
  input logic              errA,
  input logic              errB
);

  // Bits that must read zero when a half is selected at the given width
  function automatic logic [N-1:0] upperMask(input logic [LOG_N:0] w);
    logic [N-1:0] m;
    m = '0;
    for (int k = 1; k <= LOG_N; k++) begin
      if (w[k]) begin
        for (int i = 0; i < N; i++) begin
          if ((i % (1 << k)) >= ((1 << k) / 2)) m[i] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  logic widthGood;
  assign widthGood = $countones(fieldWidth) == 1 && !fieldWidth[0];

  AST_ERR_A_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    errA == (hA && lA)); // R7
  AST_ERR_B_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    errB == (hB && lB)); // R7
  AST_UPPER_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    (widthGood && (hA != lA)) |-> ((opA & upperMask(fieldWidth)) == '0)); // R5
  AST_UPPER_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    (widthGood && (hB != lB)) |-> ((opB & upperMask(fieldWidth)) == '0)); // R4
  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((rdAddrA != $past(wrAddr)) || hA || lA || (opA == $past(wrData)))); // R2

endmodule

bind halfmod_fetch halfmod_fetch_chk #(.ADDR_W(ADDR_W), .LOG_N(LOG_N)) chk_i (
  .clk(clk), .rstN(rstN),
  .rdAddrA(rdAddrA), .hA(hA), .lA(lA),
  .rdAddrB(rdAddrB), .hB(hB), .lB(lB),
  .fieldWidth(fieldWidth),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .opA(opA), .opB(opB), .errA(errA), .errB(errB)
);

// File: tb/halfmod_fetch_tb_top.sv
module halfmod_fetch_tb_top;

  localparam int ADDR_W = 2;
  localparam int LOG_N  = 4;
  localparam int N      = 1 << LOG_N;
  localparam int NREG   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic              hA = 0, lA = 0, hB = 0, lB = 0, wrEn = 0;
  logic [LOG_N:0]    fieldWidth = '0;
  logic [N-1:0]      wrData = '0;
  logic [N-1:0]      opA, opB;
  logic              errA, errB;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] shadow [NREG];

  always #2 clk = ~clk;

  halfmod_fetch #(.ADDR_W(ADDR_W), .LOG_N(LOG_N)) dut_i (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .hA(hA), .lA(lA),
    .rdAddrB(rdAddrB), .hB(hB), .lB(lB),
    .fieldWidth(fieldWidth),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .opA(opA), .opB(opB), .errA(errA), .errB(errB)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: field size 2^k, pick half by index arithmetic
  function automatic logic [N-1:0] model(input logic [N-1:0] v, input int k,
                                         input logic h, input logic l);
    logic [N-1:0] r;
    int n, half, pos, base;
    if (k == 0 || h == l) return v;
    n = 1 << k;
    half = n / 2;
    r = '0;
    for (int i = 0; i < N; i++) begin
      pos  = i % n;
      base = i - pos;
      if (pos < half) r[i] = v[base + (h ? half : 0) + pos];
    end
    return r;
  endfunction

  function automatic string tagFor(input int k, input logic h, input logic l, input bit isB);
    string t;
    if (h && l) t = "R7";
    else if (!h && !l) t = "R3";
    else if (k == 0) t = "R8";
    else if (l) t = "R4";
    else t = "R5";
    if (isB) t = {t, "/R6"};
    return t;
  endfunction

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: all registers read zero after reset
    for (int a = 0; a < NREG; a++) begin
      rdAddrA = a[ADDR_W-1:0];
      rdAddrB = a[ADDR_W-1:0];
      #1;
      check("R1 opA", opA, '0);
      check("R1 opB", opB, '0);
      @(negedge clk);
    end

    // Load distinct patterns
    for (int a = 0; a < NREG; a++) begin
      shadow[a] = N'((a + 1) * 32'h9E37 ^ 32'hB5C3 ^ (a * 32'h0F1));
      wrEn = 1; wrAddr = a[ADDR_W-1:0]; wrData = shadow[a];
      @(negedge clk);
    end
    wrEn = 0;

    // R2: same-cycle read returns old value; next cycle returns new
    rdAddrA = 2'd2; hA = 0; lA = 0;
    wrEn = 1; wrAddr = 2'd2; wrData = 16'hC3A5;
    #1;
    check("R2 same-cycle old", opA, shadow[2]);
    @(posedge clk);
    #1;
    wrEn = 0;
    check("R2 next-cycle new", opA, 16'hC3A5);
    shadow[2] = 16'hC3A5;
    @(negedge clk);
    // R2: disabled write leaves register unchanged
    wrAddr = 2'd2; wrData = 16'h0000; wrEn = 0;
    @(posedge clk);
    #1;
    check("R2 no-enable hold", opA, shadow[2]);
    @(negedge clk);

    // Sweep every address pair, width and modifier combination
    for (int ra = 0; ra < NREG; ra++) begin
      for (int rb = 0; rb < NREG; rb++) begin
        for (int k = 0; k <= LOG_N; k++) begin
          for (int m = 0; m < 16; m++) begin
            rdAddrA = ra[ADDR_W-1:0];
            rdAddrB = rb[ADDR_W-1:0];
            fieldWidth = (LOG_N+1)'(1 << k);
            hA = m[0]; lA = m[1]; hB = m[2]; lB = m[3];
            #1;
            check(tagFor(k, hA, lA, 0), opA, model(shadow[ra], k, hA, lA));
            check(tagFor(k, hB, lB, 1), opB, model(shadow[rb], k, hB, lB));
            check("R7 errA", N'(errA), N'(hA && lA));
            check("R7/R6 errB", N'(errB), N'(hB && lB));
            #1;
          end
        end
      end
    end

    // R9: malformed width vectors leave operands unchanged
    rdAddrA = 2'd1; rdAddrB = 2'd3;
    hA = 1; lA = 0; hB = 0; lB = 1;
    fieldWidth = 5'b00110;
    #1;
    check("R9 two-bit width opA", opA, shadow[1]);
    check("R9 two-bit width opB", opB, shadow[3]);
    check("R9 errA low", N'(errA), '0);
    fieldWidth = '0;
    #1;
    check("R9 zero width opA", opA, shadow[1]);
    check("R9 zero width opB", opB, shadow[3]);
    hA = 1; lA = 1;
    #1;
    check("R9 error still raised", N'(errA), N'(1));

    finishRun();
  end

endmodule